// File: doc/BRIEF.md
# Triggered Step Worker with Busy Handshake

This block is a subordinate state machine that a controlling state machine calls like a subroutine. It rests in an idle state until it samples a start request. It then walks through a fixed number of work steps, one step per clock, and returns to idle. The current step appears on a step-index output. That output stands in for the datapath work, which this block does not contain.

The worker reports progress to the controller in two ways. The busy output is high during every work step except the last. The controller can therefore move on one cycle before the worker is idle again. A one-cycle done pulse is offered as an alternative completion signal and marks the final work step. The final step always goes back to idle, so a start held high across back-to-back jobs still produces a busy period for every job.

Top module: `job_worker`

## Requirements
- R1: While rst is high at a clock edge, the next cycle shows step_o = 0, busy_o = 0 and done_o = 0, including when the reset arrives in the middle of a job.
- R2: In idle (step_o = 0) with start_i low, the worker stays in idle.
- R3: In idle with start_i high at a clock edge, the next cycle shows step_o = 1 and busy_o = 1.
- R4: Work steps advance unconditionally by one per clock, from 1 up to NUM_STEPS.
- R5: busy_o is 1 exactly when step_o is between 1 and NUM_STEPS-1, and 0 in idle and in the final step NUM_STEPS.
- R6: done_o is a single-cycle pulse that is high only when step_o = NUM_STEPS.
- R7: The final step NUM_STEPS always moves to idle on the next clock, whatever the value of start_i.
- R8: start_i has no effect while step_o is nonzero: the step sequence and the busy and done outputs are the same as with start_i low.
- R9: A start_i held high continuously produces repeated jobs with a period of NUM_STEPS+1 cycles, and busy_o rises in every job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Job request, sampled only in idle |
| busy_o | output | 1 | High during work steps 1 to NUM_STEPS-1 |
| done_o | output | 1 | One-cycle pulse in the final work step |
| step_o | output | $clog2(NUM_STEPS+1) | 0 in idle, otherwise the current work step 1..NUM_STEPS |

## Verification
The bench builds the worker with NUM_STEPS = 3, which gives the idle state and three work steps. With this value the step index takes every value of its 2-bit width, so the early busy release in step 3 and the forced return from step 3 to idle both occur within a few cycles. A start held high through several jobs shows the four-cycle repeat and the fresh busy rise in each job. Start pulses inside a job and a reset in the middle of a job are driven as directed cases.

// File: rtl/worker_pkg.sv
package worker_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // Width needed to hold an index from 0 up to n.
  function automatic int idx_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/worker_seq.sv
module worker_seq
  import worker_pkg::*;
#(
  parameter int NUM_STEPS = 3,
  localparam int SW = idx_width(NUM_STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic [SW-1:0] step_o
);

  localparam logic [SW-1:0] LAST_STEP  = SW'(NUM_STEPS);
  localparam logic [SW-1:0] FIRST_STEP = SW'(1);
  localparam logic [SW-1:0] IDLE_STEP  = '0;

  logic [SW-1:0] step_q;
  logic [SW-1:0] step_d;

  always_comb begin
    step_d = step_q;
    if (step_q == IDLE_STEP) begin
      // Leave idle only into a real work step, never loop in place.
      step_d = start_i ? FIRST_STEP : IDLE_STEP;
    end else if (step_q == LAST_STEP) begin
      // Final step always returns, regardless of the request line.
      step_d = IDLE_STEP;
    end else begin
      step_d = step_q + FIRST_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= IDLE_STEP;
    else     step_q <= step_d;
  end

  assign step_o = step_q;

endmodule

// File: rtl/worker_dec.sv
module worker_dec
  import worker_pkg::*;
#(
  parameter int NUM_STEPS = 3,
  localparam int SW = idx_width(NUM_STEPS)
) (
  input  logic [SW-1:0] step_i,
  output logic          busy_o,
  output logic          done_o
);

  localparam logic [SW-1:0] LAST_STEP = SW'(NUM_STEPS);

  phase_t phase;
  logic   at_last;

  always_comb begin
    phase   = (step_i == '0) ? PH_IDLE : PH_RUN;
    at_last = (step_i == LAST_STEP);
    // Busy drops one step early so the caller can proceed sooner.
    busy_o  = (phase == PH_RUN) && !at_last;
    done_o  = (phase == PH_RUN) && at_last;
  end

endmodule

// File: rtl/job_worker.sv
module job_worker
  import worker_pkg::*;
#(
  parameter int NUM_STEPS = 3,
  localparam int SW = idx_width(NUM_STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] step_o
);

  logic [SW-1:0] step_w;

  // A worker with fewer than two steps cannot show busy before release.
  generate
    if (NUM_STEPS < 2) begin : g_bad_param
      initial $display("job_worker: NUM_STEPS must be at least 2");
    end
  endgenerate

  worker_seq #(.NUM_STEPS(NUM_STEPS)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .step_o  (step_w)
  );

  worker_dec #(.NUM_STEPS(NUM_STEPS)) i_dec (
    .step_i (step_w),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  assign step_o = step_w;

endmodule

// File: rtl/worker_chk.sv
module worker_chk
  import worker_pkg::*;
#(
  parameter int NUM_STEPS = 3,
  localparam int SW = idx_width(NUM_STEPS)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [SW-1:0] step_o
);

  localparam logic [SW-1:0] LAST = SW'(NUM_STEPS);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (step_o == '0 && !busy_o && !done_o)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step_o == '0 && !start_i) |=> (step_o == '0)); // R2

  AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (step_o == '0 && start_i) |=> (step_o == SW'(1) && busy_o)); // R3

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step_o != '0 && step_o != LAST) |=> (step_o == $past(step_o) + SW'(1))); // R4

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (step_o == SW'(1))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, done_o})); // R6

  AST_FORCED_RETURN: assert property (@(posedge clk) disable iff (rst)
    (step_o == LAST) |=> (step_o == '0)); // R7

endmodule

bind job_worker worker_chk #(.NUM_STEPS(NUM_STEPS)) i_worker_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .step_o  (step_o)
);

// File: tb/test_job_worker.sv
module test_job_worker;

  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int SW = 2;
  localparam int NVEC = 14;

  // {start, expected step[1:0], expected busy, expected done}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b0_00_0_0, // R2 idle holds
    5'b1_01_1_0, // R3 launch
    5'b0_10_1_0, // R4 advance
    5'b1_11_0_1, // R8 start ignored, R5 R6 final step
    5'b1_00_0_0, // R7 forced return with start high
    5'b1_01_1_0, // R9 held start relaunches
    5'b1_10_1_0,
    5'b1_11_0_1,
    5'b1_00_0_0,
    5'b1_01_1_0, // R9 busy rises again
    5'b0_10_1_0,
    5'b0_11_0_1,
    5'b0_00_0_0,
    5'b0_00_0_0
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          busy_o;
  logic          done_o;
  logic [SW-1:0] step_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  job_worker #(.NUM_STEPS(N)) i_job_worker (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .step_o  (step_o)
  );

  task automatic chk(input string req, input logic [SW-1:0] s_exp,
                     input logic b_exp, input logic d_exp);
    checks++;
    if (step_o !== s_exp || busy_o !== b_exp || done_o !== d_exp) begin
      errors++;
      $display("FAIL %s: step=%0d busy=%0b done=%0b expected step=%0d busy=%0b done=%0b",
               req, step_o, busy_o, done_o, s_exp, b_exp, d_exp);
    end
  endtask

  // Drive start for one cycle, then sample after the edge at the falling edge.
  task automatic cycle(input logic s);
    start_i = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", 2'd0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][4]);
      chk($sformatf("R5 R9 vec%0d", i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset in the middle of a job
    cycle(1'b1);
    chk("R3", 2'd1, 1'b1, 1'b0);
    cycle(1'b0);
    chk("R4", 2'd2, 1'b1, 1'b0);
    rst = 1'b1;
    cycle(1'b0);
    chk("R1", 2'd0, 1'b0, 1'b0);
    rst = 1'b0;
    cycle(1'b0);
    chk("R2", 2'd0, 1'b0, 1'b0);

    // R8: start pulses inside a job change nothing
    cycle(1'b1);
    chk("R3", 2'd1, 1'b1, 1'b0);
    cycle(1'b1);
    chk("R8", 2'd2, 1'b1, 1'b0);
    cycle(1'b0);
    chk("R8", 2'd3, 1'b0, 1'b1);
    cycle(1'b0);
    chk("R6", 2'd0, 1'b0, 1'b0);
    cycle(1'b0);
    chk("R2", 2'd0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule